// File: doc/BRIEF.md
# Set-Associative Tag-Only Cache Model

This block is a synthesizable model of a single-level, set-associative, write-through cache that keeps only tags, valid bits and per-way age state. It holds no cached data. A trace source presents one access per cycle, made of a read/write flag and a 48-bit byte address. The block decides hit or miss, updates its tag array, and returns the outcome one cycle later. It also keeps four running totals: block reads from memory, block writes to memory, hits and misses.

The number of sets, the number of ways and the block size are elaboration parameters, and each must be a power of two. A per-access input selects the replacement rule, either oldest-installed (FIFO) or least-recently-used (LRU). Both rules work on the same age state, so the rule can change from one access to the next. A new block always goes into the lowest-numbered empty way of its set. A victim is chosen only when the set is full.

Top module: `tag_cache_model`

## Requirements
- R1: After reset, all four totals are zero, `rspValid` is low, and every line is empty, so the first access to any address is a miss.
- R2: The byte address splits into three fields. The lowest log2(BLOCK_BYTES) bits are the offset, the next log2(NUM_SETS) bits are the set index, and the remaining upper bits are the tag. Two addresses that differ only in the offset refer to the same block. Addresses that differ in index bits map to different sets.
- R3: Every accepted write adds exactly one to the memory-write total, whether it hits or misses.
- R4: A write miss adds one to the memory-read total, one to the miss total and one to the memory-write total, and it installs the block, so a later access to that block hits.
- R5: A read miss adds one to the memory-read total and installs the block. A read hit leaves both memory totals unchanged.
- R6: While a set has an empty way, a miss fills that way without evicting anything. NUM_WAYS distinct blocks mapped to one set therefore all stay resident.
- R7: With `policyLru` low, the victim is the block installed earliest in the set. Hits do not change this order: in a full 4-way set filled A, B, C, D, a hit on A followed by a miss on E evicts A.
- R8: With `policyLru` high, the victim is the block whose latest access (hit or fill) is the oldest in the set: filled A, B, C, D, then a hit on A followed by a miss on E evicts B.
- R9: Each accepted access adds exactly one to either the hit total or the miss total, never to both.
- R10: `reqReady` is high once reset is released. An access is accepted when `reqValid` and `reqReady` are both high. On the next cycle `rspValid` is high and `rspHit` gives the outcome. `rspValid` is low in any cycle that follows a cycle with no accepted access.
- R11: The replacement rule is sampled with each access. In a stream where `policyLru` changes from one access to the next, each hit updates the recency order only when that access selects LRU. Each fill always makes the new block the youngest in its set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access present |
| reqReady | output | 1 | Block can accept an access |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqAddr | input | ADDR_W (48) | Byte address of the access |
| policyLru | input | 1 | 1 = LRU replacement, 0 = FIFO replacement, sampled per access |
| rspValid | output | 1 | Outcome of the access accepted in the previous cycle |
| rspHit | output | 1 | 1 = hit, 0 = miss; meaningful when rspValid is high |
| memReadCount | output | CNT_W (32) | Block reads from memory |
| memWriteCount | output | CNT_W (32) | Block writes to memory |
| hitCount | output | CNT_W (32) | Hit total |
| missCount | output | CNT_W (32) | Miss total |

## Verification
The bench targets the point where FIFO and LRU give different answers: a hit on the oldest block of a full set, followed by a miss. A design that refreshes FIFO age on a hit evicts the wrong block, and the mismatch shows up as a wrong hit or miss on a later access. Write misses are checked for the full read-then-write traffic. A design that skips the allocating read, or that counts a write hit as a memory read, leaves the memory totals off by one. Addresses that differ only in the offset or only in the index check the field split, which fails if the slice positions are shifted. A long stream with a small tag range and the policy changing on each access checks the shared age state against a queue-based model. An age that wraps, or a fill that ignores an empty way, makes the design and the model disagree.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  // Strobes sent from control to datapath for one accepted access
  typedef struct packed {
    logic lookup;   // an access was accepted this cycle
    logic isWrite;  // the access is a write
    logic useLru;   // hits refresh recency
  } tcmStrobe_t;

endpackage

// File: rtl/tcm_datapath.sv
module tcm_datapath
  import tcm_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int NUM_SETS    = 4,
  parameter int NUM_WAYS    = 4,
  parameter int BLOCK_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tcmStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              lookupHit
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int AGE_W = $clog2(NUM_WAYS);
  localparam int WAY_W = AGE_W;

  logic [TAG_W-1:0] tagMem   [NUM_SETS][NUM_WAYS];
  logic             validMem [NUM_SETS][NUM_WAYS];
  logic [AGE_W-1:0] ageMem   [NUM_SETS][NUM_WAYS];

  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] reqTag;
  logic [NUM_WAYS-1:0] hitVec;
  logic [NUM_WAYS-1:0] freeVec;

  assign setIdx = addr[OFF_W +: IDX_W];
  assign reqTag = addr[OFF_W+IDX_W +: TAG_W];

  // Per-way tag compare
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign hitVec[w]  = validMem[setIdx][w] && (tagMem[setIdx][w] == reqTag);
    assign freeVec[w] = !validMem[setIdx][w];
  end

  assign lookupHit = |hitVec;

  logic [WAY_W-1:0] hitWay, freeWay, oldWay, fillWay;
  logic [AGE_W-1:0] oldAge, hitAge;
  logic             anyFree;

  always_comb begin
    hitWay  = '0;
    freeWay = '0;
    oldWay  = '0;
    oldAge  = ageMem[setIdx][0];
    anyFree = |freeVec;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
      if (ageMem[setIdx][w] > oldAge) begin
        oldAge = ageMem[setIdx][w];
        oldWay = WAY_W'(w);
      end
    end
    // scan downward so the lowest empty way wins
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (freeVec[w]) freeWay = WAY_W'(w);
    end
    fillWay = anyFree ? freeWay : oldWay;
    hitAge  = ageMem[setIdx][hitWay];
  end

  // Next ages of the addressed set
  logic [AGE_W-1:0] nextAge [NUM_WAYS];

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      nextAge[w] = ageMem[setIdx][w];
      if (!lookupHit) begin
        if (WAY_W'(w) == fillWay)
          nextAge[w] = '0;
        else if (validMem[setIdx][w])
          nextAge[w] = ageMem[setIdx][w] + 1'b1;
      end else if (strobe.useLru) begin
        if (WAY_W'(w) == hitWay)
          nextAge[w] = '0;
        else if (validMem[setIdx][w] && ageMem[setIdx][w] < hitAge)
          nextAge[w] = ageMem[setIdx][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          validMem[s][w] <= 1'b0;
          tagMem[s][w]   <= '0;
          ageMem[s][w]   <= '0;
        end
      end
    end else if (strobe.lookup) begin
      for (int w = 0; w < NUM_WAYS; w++) ageMem[setIdx][w] <= nextAge[w];
      if (!lookupHit) begin
        validMem[setIdx][fillWay] <= 1'b1;
        tagMem[setIdx][fillWay]   <= reqTag;
      end
    end
  end

  // A block is never resident in two ways of one set (R6)
  p_unique_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitVec));

  // A miss in a set with an empty way never chooses an occupied way (R6)
  p_fill_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.lookup && !lookupHit && anyFree) |-> !validMem[setIdx][fillWay]);

  // An accepted miss leaves its block resident on the next cycle (R4, R5)
  p_installed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.lookup && !lookupHit) |=> lookupHit || !$stable(addr) || !strobe.lookup);

endmodule

// File: rtl/tcm_ctrl.sv
module tcm_ctrl
  import tcm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             policyLru,
  output logic             reqReady,
  output tcmStrobe_t       strobe,
  input  logic             lookupHit,
  output logic             rspValid,
  output logic             rspHit,
  output logic [CNT_W-1:0] memReadCount,
  output logic [CNT_W-1:0] memWriteCount,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);

  logic readyQ;
  logic accept;

  assign reqReady = readyQ;
  assign accept   = reqValid && readyQ;

  always_comb begin
    strobe.lookup  = accept;
    strobe.isWrite = reqWrite;
    strobe.useLru  = policyLru;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      readyQ        <= 1'b0;
      rspValid      <= 1'b0;
      rspHit        <= 1'b0;
      memReadCount  <= '0;
      memWriteCount <= '0;
      hitCount      <= '0;
      missCount     <= '0;
    end else begin
      readyQ   <= 1'b1;
      rspValid <= accept;
      rspHit   <= accept && lookupHit;
      if (accept) begin
        if (lookupHit) begin
          hitCount <= hitCount + 1'b1;
        end else begin
          missCount    <= missCount + 1'b1;
          memReadCount <= memReadCount + 1'b1;  // block fetch, read or write miss
        end
        if (reqWrite) memWriteCount <= memWriteCount + 1'b1;
      end
    end
  end

  p_write_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reqWrite) |=> memWriteCount == $past(memWriteCount) + 1'b1);

  p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lookupHit) |=> memReadCount == $past(memReadCount) + 1'b1);

  p_read_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lookupHit && !reqWrite) |=> $stable(memReadCount) && $stable(memWriteCount));

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (hitCount + missCount) == ($past(hitCount) + $past(missCount) + 1'b1));

  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rspValid && (rspHit == $past(lookupHit)));

  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rspValid);

endmodule

// File: rtl/tag_cache_model.sv
module tag_cache_model
  import tcm_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int NUM_SETS    = 4,
  parameter int NUM_WAYS    = 4,
  parameter int BLOCK_BYTES = 4,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              policyLru,
  output logic              rspValid,
  output logic              rspHit,
  output logic [CNT_W-1:0]  memReadCount,
  output logic [CNT_W-1:0]  memWriteCount,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  tcmStrobe_t strobe;
  logic       lookupHit;

  tcm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqWrite(reqWrite), .policyLru(policyLru),
    .reqReady(reqReady), .strobe(strobe), .lookupHit(lookupHit),
    .rspValid(rspValid), .rspHit(rspHit),
    .memReadCount(memReadCount), .memWriteCount(memWriteCount),
    .hitCount(hitCount), .missCount(missCount)
  );

  tcm_datapath #(
    .ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS),
    .NUM_WAYS(NUM_WAYS), .BLOCK_BYTES(BLOCK_BYTES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .addr(reqAddr), .lookupHit(lookupHit)
  );

endmodule

// File: tb/tag_cache_model_tb.sv
`timescale 1ns/1ps
module tag_cache_model_tb;

  localparam int SETS = 4;
  localparam int WAYS = 4;
  localparam int OFFW = 2;
  localparam int IDXW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [47:0] reqAddr = '0;
  logic        policyLru = 1'b0;
  logic        rspValid, rspHit;
  logic [31:0] memReadCount, memWriteCount, hitCount, missCount;

  always #2.5 clk = ~clk;

  tag_cache_model u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .policyLru(policyLru),
    .rspValid(rspValid), .rspHit(rspHit),
    .memReadCount(memReadCount), .memWriteCount(memWriteCount),
    .hitCount(hitCount), .missCount(missCount)
  );

  // Behavioural reference: per set, a queue ordered oldest first
  longint unsigned refQ [SETS][$];
  int expRd, expWr, expHit, expMiss;
  bit expRspValid, expRspHit;
  int nVec, nBad;
  bit done;

  function automatic longint unsigned mk(int tag, int set, int off);
    return (longint'(tag) << (OFFW + IDXW)) | (longint'(set) << OFFW) | longint'(off);
  endfunction

  function automatic bit refAccess(bit wr, longint unsigned a, bit lru);
    int s;
    longint unsigned t;
    int pos;
    s = int'((a >> OFFW) % SETS);
    t = a >> (OFFW + IDXW);
    pos = -1;
    foreach (refQ[s][i]) if (refQ[s][i] == t) pos = i;
    if (wr) expWr++;
    if (pos >= 0) begin
      expHit++;
      if (lru) begin
        refQ[s].delete(pos);
        refQ[s].push_back(t);
      end
      return 1'b1;
    end
    expMiss++;
    expRd++;
    if (refQ[s].size() == WAYS) void'(refQ[s].pop_front());
    refQ[s].push_back(t);
    return 1'b0;
  endfunction

  task automatic check(string req);
    nVec++;
    if (rspValid !== expRspValid || (expRspValid && rspHit !== expRspHit) ||
        memReadCount !== 32'(expRd) || memWriteCount !== 32'(expWr) ||
        hitCount !== 32'(expHit) || missCount !== 32'(expMiss)) begin
      nBad++;
      $display("FAIL %s: got v=%0b h=%0b rd=%0d wr=%0d hit=%0d miss=%0d exp v=%0b h=%0b rd=%0d wr=%0d hit=%0d miss=%0d",
        req, rspValid, rspHit, memReadCount, memWriteCount, hitCount, missCount,
        expRspValid, expRspHit, expRd, expWr, expHit, expMiss);
    end
  endtask

  // Called at a negedge; returns at the next negedge after checking
  task automatic access(bit wr, longint unsigned a, bit lru, string req);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a[47:0]; policyLru = lru;
    expRspHit = refAccess(wr, a, lru);
    expRspValid = 1'b1;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check(req);
  endtask

  task automatic idle(string req);
    reqValid = 1'b0;
    expRspValid = 1'b0;
    @(posedge clk); @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    // R1 reset state; R10 ready after reset
    expRspValid = 1'b0;
    check("R1");
    nVec++;
    if (reqReady !== 1'b1) begin
      nBad++;
      $display("FAIL R10: got reqReady=%0b exp 1", reqReady);
    end

    access(0, mk(1, 0, 0), 0, "R1");   // first access misses
    access(0, mk(1, 0, 3), 0, "R2");   // same block, other offset: hit (R5 quiet)
    access(0, mk(1, 1, 0), 0, "R2");   // same tag, other set: miss
    access(0, mk(2, 0, 1), 0, "R2");   // other tag, same set: miss
    idle("R10");
    access(1, mk(7, 2, 0), 0, "R4");   // write miss: read+write
    access(1, mk(7, 2, 2), 0, "R3");   // write hit: write only
    access(0, mk(7, 2, 1), 0, "R4");   // installed block hits
    idle("R10");

    // R6: fill set 1 fully (tag 1 already there)
    for (int t = 2; t <= 4; t++) access(0, mk(t, 1, 0), 0, "R6");
    for (int t = 1; t <= 4; t++) access(0, mk(t, 1, 0), 0, "R6");

    // R7 FIFO on set 3: A..D, hit A, E evicts A
    for (int t = 10; t <= 13; t++) access(0, mk(t, 3, 0), 0, "R7");
    access(0, mk(10, 3, 0), 0, "R7");
    access(0, mk(14, 3, 0), 0, "R7");
    access(0, mk(11, 3, 0), 0, "R7");  // B still present
    access(0, mk(10, 3, 0), 0, "R7");  // A evicted: miss

    // R8 LRU on set 0 after clearing by new tags
    for (int t = 20; t <= 23; t++) access(0, mk(t, 0, 0), 1, "R8");
    access(0, mk(20, 0, 0), 1, "R8");
    access(0, mk(24, 0, 0), 1, "R8");  // evicts 21
    access(0, mk(20, 0, 0), 1, "R8");  // hit
    access(0, mk(21, 0, 0), 1, "R8");  // miss

    // R11 / R9: mixed stream, policy per access
    for (int i = 0; i < 600; i++) begin
      access(1'($urandom_range(0, 1)),
             mk(int'($urandom_range(0, 6)), int'($urandom_range(0, SETS - 1)),
                int'($urandom_range(0, 3))),
             1'($urandom_range(0, 1)), "R11");
      if (i % 50 == 0) idle("R9");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule